// File: doc/BRIEF.md
# Byte-Step Two-Wire Bus Master

This block is a master for a two-wire serial bus (clock line and data line, both open-drain). Software drives it one step at a time. A step is a START, a repeated START, one transmitted byte, one received byte, or a STOP. Software loads a byte register and then writes a control register with the step-done flag clear, which launches the next step. When the step finishes, the block sets the step-done flag and posts a fixed status code that tells software what happened on the bus.

Each bit on the wire is split into four quarters of `QTR` clock cycles. At the end of a quarter in which the clock line should be high, the engine waits until the line really is high, so a slow target can hold the clock low. An interrupt is raised while it is enabled and the status code is anything other than idle. Two override bits in the interrupt register can force either bus line low by hand. Software uses them to clock a stuck target free of the data line and then release the bus.

Top module: `twi_byte_master`

## Requirements
- R1: After reset the status reads 0xF8, the control and data registers read 0x00, the interrupt is low, and neither line is driven low.
- R2: Writing the control register (select 1) with bus-enable (bit 6) and START (bit 5) set and the step-done flag (bit 3) clear sends a START. On completion the step-done flag is set and the status reads 0x08 when no transfer was open, or 0x10 for a repeated START inside an open transfer.
- R3: The first byte after a START is the address, sent MSB first from the data register (select 0). Its bit 0 selects read (1) or write (0). The status reads 0x18 (write) or 0x40 (read) when the target acknowledges, and 0x20 (write) or 0x48 (read) when it does not.
- R4: Each later byte of a write transfer is sent MSB first. The status reads 0x28 when it is acknowledged and 0x30 when it is not.
- R5: In a read transfer each step receives one byte, MSB first, into the data register. The master drives the acknowledge low when assert-acknowledge (control bit 2) is set, giving status 0x50. With that bit clear it leaves the line released, giving status 0x58.
- R6: A STOP request (control bit 4 with bit 6, bit 5 and bit 3 clear) makes the status read 0xF8 from the next cycle. The STOP condition then follows, and both lines end up released.
- R7: The step-done flag is set only when a step completes. A control write with bit 3 set launches no step and does not clear the flag.
- R8: Writes to the control or data register while a step is running are ignored.
- R9: A control write with bus-enable clear launches no step.
- R10: The interrupt output is high exactly when the interrupt enable (interrupt register, select 2, bit 6) is set and the status is not 0xF8.
- R11: In the interrupt register, bit 9 forces the clock line low and bit 8 forces the data line low, from the next cycle. Writing zero returns both lines to the engine.
- R12: While another device holds the clock line low, the engine does not end a clock-high quarter. Every clock-high pulse lasts at least `QTR` cycles, and the bytes still transfer correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 data, 1 control, 2 interrupt |
| reg_wdata | input | 10 | Write data |
| ctl_rd | output | 8 | Control readback: {7:ce, 6:enable, 3:step-done, 2:assert-ack} |
| data_rd | output | 8 | Data register readback |
| stat_rd | output | 8 | Status code |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | Sensed clock line |
| sda_in | input | 1 | Sensed data line |
| scl_oe | output | 1 | Drive clock line low |
| sda_oe | output | 1 | Drive data line low |

## Verification
Several properties take the software protocol for granted. The STOP property assumes START and STOP are not requested in the same control write. The write-ignore checks assume software never writes the data register in the cycle a received byte lands. The bench keeps to both rules: it requests START and STOP only in separate writes, and it makes its only mid-step register writes while a transmit step is running. The properties also assume the lines read back exactly what the master and a single well-behaved target drive. The bench target therefore changes the data line only while the clock is low, and it stretches the clock only right after a falling edge.

// File: rtl/twi_byte_master.sv
module twi_byte_master #(
  parameter int QTR = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_sel,
  input  logic [9:0] reg_wdata,
  output logic [7:0] ctl_rd,
  output logic [7:0] data_rd,
  output logic [7:0] stat_rd,
  output logic       irq,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int CW = (QTR > 2) ? $clog2(QTR) : 1;
  localparam logic [7:0] IDLE = 8'hF8;

  typedef enum logic [1:0] {K_START, K_STOP, K_BYTE} kind_t;

  logic ce, en, aak, iflg, int_en, frc_scl, frc_sda;
  logic [7:0] stat, dat, sh;
  logic busy, rx, is_addr, in_txn, rd_mode, smp;
  logic scl_r, sda_r, p_scl, p_sda;
  kind_t kind;
  logic [1:0] q;
  logic [3:0] bitn;
  logic [CW-1:0] cnt;

  always_comb begin
    case (kind)
      K_START: begin p_scl = (q == 2'd0) ? !in_txn : (q != 2'd3); p_sda = (q < 2'd2); end
      K_STOP:  begin p_scl = (q != 2'd0); p_sda = (q >= 2'd2); end
      default: begin
        p_scl = (q == 2'd1) || (q == 2'd2);
        if (bitn == 4'd8) p_sda = rx ? !aak : 1'b1;
        else              p_sda = rx ? 1'b1 : sh[7];
      end
    endcase
  end

  wire q_end     = cnt == CW'(QTR - 1);
  wire stall     = p_scl && !scl_in;
  wire adv       = busy && q_end && !stall;
  wire slot_end  = adv && (q == 2'd3);
  wire step_done = slot_end && (kind != K_BYTE || bitn == 4'd8);
  wire ctl_wr    = reg_we && reg_sel == 2'd1 && !busy;
  wire go        = ctl_wr && reg_wdata[6] && !reg_wdata[3];
  wire go_sta    = go && reg_wdata[5];
  wire go_stp    = go && !reg_wdata[5] && reg_wdata[4];
  wire go_byte   = go && !reg_wdata[5] && !reg_wdata[4] && in_txn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {ce, en, aak, iflg, int_en, frc_scl, frc_sda} <= '0;
      stat <= IDLE; dat <= '0; sh <= '0;
      {busy, rx, is_addr, in_txn, rd_mode, smp} <= '0;
      scl_r <= 1'b1; sda_r <= 1'b1;
      kind <= K_STOP; q <= '0; bitn <= '0; cnt <= '0;
    end else begin
      if (reg_we && reg_sel == 2'd2) begin
        frc_scl <= reg_wdata[9]; frc_sda <= reg_wdata[8]; int_en <= reg_wdata[6];
      end
      if (reg_we && reg_sel == 2'd0 && !busy) dat <= reg_wdata[7:0];
      if (ctl_wr) begin
        ce <= reg_wdata[7]; en <= reg_wdata[6]; aak <= reg_wdata[2];
        if (!reg_wdata[3]) iflg <= 1'b0;
      end
      if (go_sta || (go_stp && in_txn) || go_byte) begin
        busy <= 1'b1; cnt <= '0; q <= '0; bitn <= '0;
      end
      if (go_sta) kind <= K_START;
      if (go_stp) begin
        stat <= IDLE;
        if (in_txn) kind <= K_STOP;
      end
      if (go_byte) begin
        kind <= K_BYTE; sh <= dat; rx <= !is_addr && rd_mode;
        if (is_addr) rd_mode <= dat[0];
      end
      if (busy) begin
        scl_r <= p_scl; sda_r <= p_sda;
        if (!q_end) cnt <= cnt + 1'b1;
        else if (!stall) begin cnt <= '0; q <= q + 2'd1; end
        if (adv && q == 2'd2) smp <= sda_in;
        if (slot_end && kind == K_BYTE && bitn != 4'd8) begin
          sh <= {sh[6:0], smp}; bitn <= bitn + 4'd1;
        end
        if (step_done) begin
          busy <= 1'b0;
          case (kind)
            K_START: begin stat <= in_txn ? 8'h10 : 8'h08; in_txn <= 1'b1; is_addr <= 1'b1; iflg <= 1'b1; end
            K_STOP:  in_txn <= 1'b0;
            default: begin
              iflg <= 1'b1; is_addr <= 1'b0;
              if (rx) begin dat <= sh; stat <= aak ? 8'h50 : 8'h58; end
              else if (is_addr) stat <= rd_mode ? (smp ? 8'h48 : 8'h40) : (smp ? 8'h20 : 8'h18);
              else stat <= smp ? 8'h30 : 8'h28;
            end
          endcase
        end
      end
    end
  end

  assign ctl_rd  = {ce, en, 2'b00, iflg, aak, 2'b00};
  assign data_rd = dat;
  assign stat_rd = stat;
  assign irq     = int_en && (stat != IDLE);
  assign scl_oe  = !scl_r || frc_scl;
  assign sda_oe  = !sda_r || frc_sda;
endmodule

// File: rtl/twi_byte_master_chk.sv
module twi_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [1:0] reg_sel,
  input logic [9:0] reg_wdata,
  input logic [7:0] ctl_rd,
  input logic [7:0] stat_rd,
  input logic       irq,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       busy
);
  // R2
  stat_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd inside {8'h08, 8'h10, 8'h18, 8'h20, 8'h28, 8'h30, 8'h40, 8'h48, 8'h50, 8'h58, 8'hF8});
  // R7
  flag_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_rd[3]) |-> ($past(busy) && stat_rd != 8'hF8));
  // R6
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd1 && reg_wdata[6:3] == 4'b1010 && !busy) |=> stat_rd == 8'hF8);
  // R10
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd == 8'hF8) |-> !irq);
  // R11
  scl_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd2 && reg_wdata[9]) |=> scl_oe);
  // R11
  sda_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd2 && reg_wdata[8]) |=> sda_oe);
  // R8
  busy_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_sel == 2'd1) |=> $stable(ctl_rd[2]));
endmodule

bind twi_byte_master twi_byte_master_chk i_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .ctl_rd(ctl_rd), .stat_rd(stat_rd), .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy)
);

// File: tb/test_twi_byte_master.sv
module test_twi_byte_master;
  localparam int QTR = 2;
  localparam int STR = 10;
  localparam logic [6:0] SLV = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [9:0] reg_wdata = '0;
  logic [7:0] ctl_rd, data_rd, stat_rd;
  logic irq, scl_oe, sda_oe;
  logic s_sda_low = 1'b0, s_scl_low = 1'b0;
  logic nack_data = 1'b0, stretch_en = 1'b0, mon_en = 1'b0;
  int nchk = 0, nerr = 0;

  wire scl_line = !(scl_oe || s_scl_low);
  wire sda_line = !(sda_oe || s_sda_low);

  always #5 clk = !clk;

  twi_byte_master #(.QTR(QTR)) i_twi_byte_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .ctl_rd(ctl_rd), .data_rd(data_rd), .stat_rd(stat_rd), .irq(irq),
    .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  function automatic logic [7:0] rd_val(input int i);
    return 8'h3C ^ (8'(i) * 8'd29);
  endfunction

  // target model
  logic ps = 1'b1, pd = 1'b1;
  logic active = 0, armed = 0, first = 0, match = 0, rdir = 0, m_ack = 0;
  int bitc = 0, ridx = 0, wcnt = 0, stops = 0;
  logic [7:0] shr = '0, txb = '0;
  logic [7:0] wlog [16];

  always @(scl_line or sda_line) begin
    if (sda_line != pd && scl_line && ps) begin
      if (!sda_line) begin active = 1; armed = 0; first = 1; bitc = 0; ridx = 0; s_sda_low = 0; end
      else begin active = 0; s_sda_low = 0; stops++; end
    end
    if (scl_line && !ps && active) begin
      if (bitc < 8) shr = {shr[6:0], sda_line};
      else m_ack = !sda_line;
    end
    if (!scl_line && ps && active) begin
      if (!armed) armed = 1;
      else if (bitc == 7) begin
        bitc = 8;
        if (first) begin match = (shr[7:1] == SLV); rdir = shr[0]; s_sda_low = match; end
        else if (!rdir) begin
          if (match) begin
            if (wcnt < 16) wlog[wcnt] = shr;
            wcnt++;
          end
          s_sda_low = match && !nack_data;
        end else s_sda_low = 0;
      end else if (bitc == 8) begin
        bitc = 0;
        if (match && rdir && (first || m_ack)) begin
          txb = rd_val(ridx); ridx++; s_sda_low = !txb[7];
        end else s_sda_low = 0;
        first = 0;
      end else begin
        bitc++;
        if (match && rdir && !first) s_sda_low = !txb[7 - bitc];
      end
    end
    ps = scl_line; pd = sda_line;
  end

  always @(negedge scl_line) if (stretch_en) begin
    s_scl_low = 1'b1;
    repeat (STR) @(posedge clk);
    s_scl_low = 1'b0;
  end

  int hi_cnt = 0, min_hi = 1000;
  always @(posedge clk) if (mon_en) begin
    if (scl_line) hi_cnt++;
    else begin
      if (hi_cnt > 0 && hi_cnt < min_hi) min_hi = hi_cnt;
      hi_cnt = 0;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [9:0] v);
    @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wait_flag(output int cyc);
    cyc = -1;
    for (int i = 0; i < 4000; i++) begin
      if (ctl_rd[3]) begin cyc = i; return; end
      @(negedge clk);
    end
    chk(1'b0, "step-done timeout", 0, 1);
  endtask

  task automatic step(input logic [9:0] c, input logic [7:0] exp, input string req, output int cyc);
    wr(2'd1, c);
    wait_flag(cyc);
    chk(stat_rd == exp, req, stat_rd, exp);
  endtask

  task automatic tx(input logic [7:0] b, input logic [7:0] exp, input string req, output int cyc);
    wr(2'd0, {2'b00, b});
    step(10'h040, exp, req, cyc);
  endtask

  task automatic stop_bus(input string req);
    int s0;
    s0 = stops;
    wr(2'd1, 10'h050);
    chk(stat_rd == 8'hF8, req, stat_rd, 8'hF8);
    repeat (12 * QTR) @(negedge clk);
    chk(!scl_oe && !sda_oe && stops == s0 + 1, req, {scl_oe, sda_oe}, 0);
  endtask

  initial begin
    int cyc, dur0, dur1, w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(stat_rd == 8'hF8, "R1 status", stat_rd, 8'hF8);
    chk(ctl_rd == 8'h00 && data_rd == 8'h00, "R1 regs", {ctl_rd, data_rd}, 0);
    chk(!irq && !scl_oe && !sda_oe, "R1 lines/irq", {irq, scl_oe, sda_oe}, 0);

    // R11 override sweep
    for (int v = 0; v < 4; v++) begin
      wr(2'd2, 10'(v << 8));
      chk(scl_oe == v[1] && sda_oe == v[0], "R11 force", {scl_oe, sda_oe}, v);
    end
    wr(2'd2, 10'h000);
    chk(!scl_oe && !sda_oe, "R11 release", {scl_oe, sda_oe}, 0);

    // R9 no enable
    wr(2'd1, 10'h020);
    repeat (20) @(negedge clk);
    chk(stat_rd == 8'hF8 && !ctl_rd[3] && !scl_oe && !sda_oe, "R9 no step", stat_rd, 8'hF8);
    // R7 flag bit written set
    wr(2'd1, 10'h068);
    repeat (20) @(negedge clk);
    chk(stat_rd == 8'hF8 && !ctl_rd[3] && !sda_oe, "R7 no step", stat_rd, 8'hF8);

    // R10 enable interrupt while idle
    wr(2'd2, 10'h040);
    chk(!irq, "R10 idle irq", irq, 0);

    // write transfer
    w0 = wcnt;
    step(10'h060, 8'h08, "R2 start", cyc);
    chk(irq, "R10 irq on busy status", irq, 1);
    tx({SLV, 1'b0}, 8'h18, "R3 addr write ack", cyc);
    for (int k = 0; k < 5; k++) begin
      tx(8'hC3 ^ 8'(k * 8'h11), 8'h28, "R4 data ack", cyc);
      if (k == 0) dur0 = cyc;
    end
    for (int k = 0; k < 5; k++)
      chk(wlog[w0 + k] == (8'hC3 ^ 8'(k * 8'h11)), "R4 target byte", wlog[w0 + k], 8'hC3 ^ 8'(k * 8'h11));
    stop_bus("R6 stop");
    chk(!irq, "R10 irq after stop", irq, 0);
    wr(2'd2, 10'h000);
    chk(!irq, "R10 irq disabled", irq, 0);

    // read sweep over lengths, repeated start on the last
    for (int len = 1; len <= 3; len++) begin
      step(10'h060, 8'h08, "R2 start", cyc);
      if (len == 3) begin
        tx({SLV, 1'b0}, 8'h18, "R3 addr write ack", cyc);
        tx(8'h5E, 8'h28, "R4 data ack", cyc);
        step(10'h060, 8'h10, "R2 repeated start", cyc);
      end
      tx({SLV, 1'b1}, 8'h40, "R3 addr read ack", cyc);
      for (int i = 0; i < len; i++) begin
        if (i < len - 1) step(10'h044, 8'h50, "R5 rx ack", cyc);
        else             step(10'h040, 8'h58, "R5 rx no ack", cyc);
        chk(data_rd == rd_val(i), "R5 rx byte", data_rd, rd_val(i));
      end
      stop_bus("R6 stop after read");
    end

    // negative acknowledges
    step(10'h060, 8'h08, "R2 start", cyc);
    tx({7'h21, 1'b0}, 8'h20, "R3 addr write nack", cyc);
    stop_bus("R6 stop");
    step(10'h060, 8'h08, "R2 start", cyc);
    tx({7'h21, 1'b1}, 8'h48, "R3 addr read nack", cyc);
    stop_bus("R6 stop");
    nack_data = 1'b1;
    step(10'h060, 8'h08, "R2 start", cyc);
    tx({SLV, 1'b0}, 8'h18, "R3 addr write ack", cyc);
    tx(8'h77, 8'h30, "R4 data nack", cyc);
    stop_bus("R6 stop");
    nack_data = 1'b0;

    // R8 writes during a step
    w0 = wcnt;
    step(10'h060, 8'h08, "R2 start", cyc);
    tx({SLV, 1'b0}, 8'h18, "R3 addr write ack", cyc);
    wr(2'd0, 10'h096);
    wr(2'd1, 10'h040);
    wr(2'd0, 10'h0FF);
    wr(2'd1, 10'h064);
    wait_flag(cyc);
    chk(stat_rd == 8'h28, "R8 status unchanged by busy write", stat_rd, 8'h28);
    chk(data_rd == 8'h96, "R8 data unchanged", data_rd, 8'h96);
    chk(!ctl_rd[2], "R8 ctl unchanged", ctl_rd, 8'h48);
    chk(wlog[w0] == 8'h96, "R8 target byte", wlog[w0], 8'h96);
    stop_bus("R6 stop");

    // R12 clock stretching
    w0 = wcnt;
    stretch_en = 1'b1;
    step(10'h060, 8'h08, "R2 start", cyc);
    tx({SLV, 1'b0}, 8'h18, "R3 addr write ack", cyc);
    min_hi = 1000; hi_cnt = 0; mon_en = 1'b1;
    tx(8'hA7, 8'h28, "R12 stretched byte", cyc);
    dur1 = cyc;
    mon_en = 1'b0;
    chk(wlog[w0] == 8'hA7, "R12 target byte", wlog[w0], 8'hA7);
    chk(min_hi >= QTR, "R12 high pulse", min_hi, QTR);
    chk(dur1 > dur0 + 18, "R12 slower step", dur1, dur0 + 18);
    stop_bus("R6 stop");
    stretch_en = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule